// File: doc/BRIEF.md
# Output-Compare and PWM Channel

This block is one channel of a general-purpose timer, used in output mode. A counter outside the block supplies its current value and an update pulse. On every clock the channel compares that value with an active compare register and moves a reference waveform according to a 3-bit behaviour code. The codes cover a held level, set, clear or toggle on a match, a level forced low or high, and two complementary pulse-width modes.

Software writes the new compare value into a shadow register. The shadow is copied into the active compare register only on a counter update pulse, so a new duty cycle starts cleanly at a period boundary. Every match raises a one-cycle event and a sticky flag. An interrupt line and a DMA request are each gated by their own enable. A select bit chooses whether the DMA request follows compare matches or update pulses. A 2-bit direction field marks the channel as output (00) or as one of three input routings. The field is locked while the channel is enabled.

Top module: `occ_channel`

## Requirements
- R1: With behaviour code 000 (hold), the reference output does not change for any counter value.
- R2: With code 001 the reference goes to 1 on a clock where the counter equals the active compare value. With code 010 it goes to 0 on such a clock. On other clocks it keeps its level.
- R3: With code 011 the reference inverts on every clock where the counter equals the active compare value.
- R4: Code 100 drives the reference to 0 and code 101 drives it to 1, one clock after the code is in place, whatever the counter holds.
- R5: With code 110 the reference becomes 1 when the counter is below the active compare value and 0 otherwise. Code 111 gives the inverse. The reference is registered, so it appears one clock after the counter value.
- R6: The direction field is 00 for output, and 01, 10 and 11 for the input routings. A configuration write changes the field only when the stored channel enable is 0 before that write. While the field is not 00, the reference holds and no compare event or flag is produced.
- R7: The channel pin equals the reference when the channel is enabled and the direction is 00. Otherwise the pin is 0.
- R8: A shadow write never changes the active compare value by itself. On an update pulse the active value takes the shadow contents held before that clock edge.
- R9: On each clock with a match in output direction, the compare event is high for exactly the next cycle and the status flag is set. A clear pulse resets the flag. If a match and a clear happen on the same clock, the set wins.
- R10: With DMA-select 0 the DMA request pulses one clock after each compare match. With DMA-select 1 it pulses one clock after each update pulse.
- R11: The interrupt line equals the status flag ANDed with the interrupt enable. The DMA request stays 0 while the DMA enable is 0.
- R12: After a synchronous reset: compare values 0, reference 0, flag 0, direction 00, code 000, channel disabled and all enables 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Behaviour code to write |
| cfg_dir | input | 2 | Direction field to write (applied only while disabled) |
| cfg_en | input | 1 | Channel enable to write |
| cfg_dma_upd | input | 1 | DMA select: 0 = on compare match, 1 = on update |
| cfg_irq_en | input | 1 | Interrupt enable to write |
| cfg_dma_en | input | 1 | DMA enable to write |
| pre_we | input | 1 | Shadow compare write strobe |
| pre_data | input | CNT_W | Shadow compare write data |
| upd_evt | input | 1 | Counter update pulse |
| cnt_val | input | CNT_W | Current counter value |
| sts_clr | input | 1 | Clears the status flag (software writing 0) |
| oc_ref | output | 1 | Reference waveform |
| oc_pin | output | 1 | Gated channel output |
| cmp_evt | output | 1 | One-cycle compare event |
| cmp_flag | output | 1 | Sticky compare status flag |
| ch_irq | output | 1 | Channel interrupt |
| ch_dma | output | 1 | Channel DMA request pulse |
| dir_q | output | 2 | Current direction field |
| cmp_active | output | CNT_W | Active compare value |

## Verification
A wrong active compare value moves the match. The reference edge in every code then shifts, and the event, flag and DMA pulses appear on the wrong clock, visible within one cycle of the counter passing either value. A corrupted behaviour code or reference bit shows on oc_ref the clock after the next counter step. A direction field that escapes its lock shows at once on dir_q and silences events and the pin. The bench compares every output on every clock against its own model, so any of these shows up within a cycle.

// File: rtl/occ_pkg.sv
package occ_pkg;

  typedef enum logic [2:0] {
    OM_HOLD     = 3'b000,
    OM_SET      = 3'b001,
    OM_CLEAR    = 3'b010,
    OM_TOGGLE   = 3'b011,
    OM_FORCE_LO = 3'b100,
    OM_FORCE_HI = 3'b101,
    OM_PWM_A    = 3'b110,
    OM_PWM_B    = 3'b111
  } oc_mode_e;

  typedef enum logic [1:0] {
    DIR_OUT       = 2'b00,
    DIR_IN_DIRECT = 2'b01,
    DIR_IN_CROSS  = 2'b10,
    DIR_IN_TRIG   = 2'b11
  } ch_dir_e;

  typedef struct packed {
    oc_mode_e mode;
    ch_dir_e  dir;
    logic     en;
    logic     dma_on_upd;
    logic     irq_en;
    logic     dma_en;
  } ch_cfg_t;

endpackage

// File: rtl/occ_cfg_regs.sv
module occ_cfg_regs
  import occ_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_en,
  input  ch_cfg_t wr_cfg,
  output ch_cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q.mode       <= wr_cfg.mode;
      cfg_q.en         <= wr_cfg.en;
      cfg_q.dma_on_upd <= wr_cfg.dma_on_upd;
      cfg_q.irq_en     <= wr_cfg.irq_en;
      cfg_q.dma_en     <= wr_cfg.dma_en;
      if (!cfg_q.en) cfg_q.dir <= wr_cfg.dir;
    end
  end

  // R6
  dir_lock_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_q.en |=> $stable(cfg_q.dir));

  // R6
  dir_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/occ_cmp_unit.sv
module occ_cmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             out_mode,
  input  logic             upd,
  input  logic             pre_we,
  input  logic [CNT_W-1:0] pre_wdata,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] act_q,
  output logic             hit,
  output logic             below
);

  logic [CNT_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (pre_we) pre_q <= pre_wdata;
      if (upd)    act_q <= pre_q;
    end
  end

  assign hit   = out_mode && (cnt == act_q);
  assign below = (cnt < act_q);

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(act_q));

  // R8
  act_load_chk: assert property (@(posedge clk) disable iff (rst)
    upd |=> act_q == $past(pre_q));

endmodule

// File: rtl/occ_ref_gen.sv
module occ_ref_gen
  import occ_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  oc_mode_e mode,
  input  logic     out_mode,
  input  logic     hit,
  input  logic     below,
  output logic     ref_q
);

  logic ref_d;

  always_comb begin
    ref_d = ref_q;
    if (out_mode) begin
      unique case (mode)
        OM_HOLD:     ref_d = ref_q;
        OM_SET:      ref_d = hit ? 1'b1 : ref_q;
        OM_CLEAR:    ref_d = hit ? 1'b0 : ref_q;
        OM_TOGGLE:   ref_d = hit ? ~ref_q : ref_q;
        OM_FORCE_LO: ref_d = 1'b0;
        OM_FORCE_HI: ref_d = 1'b1;
        OM_PWM_A:    ref_d = below;
        OM_PWM_B:    ref_d = ~below;
        default:     ref_d = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= ref_d;
  end

  // R1
  hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (out_mode && mode == OM_HOLD) |=> $stable(ref_q));

  // R4
  force_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (out_mode && mode == OM_FORCE_LO) |=> !ref_q);

  // R4
  force_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (out_mode && mode == OM_FORCE_HI) |=> ref_q);

  // R6
  in_dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_mode |=> $stable(ref_q));

endmodule

// File: rtl/occ_evt_ctrl.sv
module occ_evt_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic upd,
  input  logic clr,
  input  logic dma_on_upd,
  input  logic irq_en,
  input  logic dma_en,
  output logic evt_q,
  output logic sts_q,
  output logic dma_q,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= 1'b0;
      sts_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      evt_q <= hit;
      if (hit)      sts_q <= 1'b1;
      else if (clr) sts_q <= 1'b0;
      dma_q <= dma_en && (dma_on_upd ? upd : hit);
    end
  end

  assign irq = sts_q && irq_en;

  // R9
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> sts_q);

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && clr) |=> sts_q);

  // R10
  dma_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_en && !dma_on_upd && hit) |=> dma_q);

  // R11
  dma_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !dma_en |=> !dma_q);

endmodule

// File: rtl/occ_channel.sv
module occ_channel
  import occ_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_mode,
  input  logic [1:0]       cfg_dir,
  input  logic             cfg_en,
  input  logic             cfg_dma_upd,
  input  logic             cfg_irq_en,
  input  logic             cfg_dma_en,
  input  logic             pre_we,
  input  logic [CNT_W-1:0] pre_data,
  input  logic             upd_evt,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             sts_clr,
  output logic             oc_ref,
  output logic             oc_pin,
  output logic             cmp_evt,
  output logic             cmp_flag,
  output logic             ch_irq,
  output logic             ch_dma,
  output logic [1:0]       dir_q,
  output logic [CNT_W-1:0] cmp_active
);

  ch_cfg_t wr_cfg;
  ch_cfg_t cfg;
  logic    out_mode;
  logic    hit;
  logic    below;

  always_comb begin
    wr_cfg.mode       = oc_mode_e'(cfg_mode);
    wr_cfg.dir        = ch_dir_e'(cfg_dir);
    wr_cfg.en         = cfg_en;
    wr_cfg.dma_on_upd = cfg_dma_upd;
    wr_cfg.irq_en     = cfg_irq_en;
    wr_cfg.dma_en     = cfg_dma_en;
  end

  occ_cfg_regs u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_we),
    .wr_cfg (wr_cfg),
    .cfg_q  (cfg)
  );

  assign out_mode = (cfg.dir == DIR_OUT);

  occ_cmp_unit #(.CNT_W(CNT_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .out_mode  (out_mode),
    .upd       (upd_evt),
    .pre_we    (pre_we),
    .pre_wdata (pre_data),
    .cnt       (cnt_val),
    .act_q     (cmp_active),
    .hit       (hit),
    .below     (below)
  );

  occ_ref_gen u_ref (
    .clk      (clk),
    .rst      (rst),
    .mode     (cfg.mode),
    .out_mode (out_mode),
    .hit      (hit),
    .below    (below),
    .ref_q    (oc_ref)
  );

  occ_evt_ctrl u_evt (
    .clk        (clk),
    .rst        (rst),
    .hit        (hit),
    .upd        (upd_evt),
    .clr        (sts_clr),
    .dma_on_upd (cfg.dma_on_upd),
    .irq_en     (cfg.irq_en),
    .dma_en     (cfg.dma_en),
    .evt_q      (cmp_evt),
    .sts_q      (cmp_flag),
    .dma_q      (ch_dma),
    .irq        (ch_irq)
  );

  assign oc_pin = cfg.en && out_mode && oc_ref;
  assign dir_q  = cfg.dir;

  // R7
  pin_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.en || !out_mode) |-> !oc_pin);

  // R6
  no_evt_input_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_mode && $stable(cfg.dir)) |=> !cmp_evt);

endmodule

// File: tb/test_occ_channel.sv
module test_occ_channel;
  localparam int W = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst, cfg_we, cfg_en, cfg_dma_upd, cfg_irq_en, cfg_dma_en;
  logic [2:0]   cfg_mode;
  logic [1:0]   cfg_dir;
  logic         pre_we, upd_evt, sts_clr;
  logic [W-1:0] pre_data, cnt_val;
  logic         oc_ref, oc_pin, cmp_evt, cmp_flag, ch_irq, ch_dma;
  logic [1:0]   dir_q;
  logic [W-1:0] cmp_active;

  occ_channel #(.CNT_W(W)) i_occ_channel (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir),
    .cfg_en(cfg_en), .cfg_dma_upd(cfg_dma_upd), .cfg_irq_en(cfg_irq_en),
    .cfg_dma_en(cfg_dma_en), .pre_we(pre_we), .pre_data(pre_data), .upd_evt(upd_evt),
    .cnt_val(cnt_val), .sts_clr(sts_clr), .oc_ref(oc_ref), .oc_pin(oc_pin),
    .cmp_evt(cmp_evt), .cmp_flag(cmp_flag), .ch_irq(ch_irq), .ch_dma(ch_dma),
    .dir_q(dir_q), .cmp_active(cmp_active)
  );

  typedef struct {
    int           due;
    string        req;
    logic         r, p, e, s, i, d;
    logic [1:0]   dir;
    logic [W-1:0] act;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // reference model state
  logic [2:0]   m_mode;
  logic [1:0]   m_dir;
  logic         m_en, m_sel, m_ie, m_de, m_ref, m_evt, m_sts, m_dma;
  logic [W-1:0] m_pre, m_act;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops due items and compares all outputs
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t x;
      x = q.pop_front();
      checks++;
      if ({oc_ref, oc_pin, cmp_evt, cmp_flag, ch_irq, ch_dma, dir_q, cmp_active} !==
          {x.r, x.p, x.e, x.s, x.i, x.d, x.dir, x.act}) begin
        errors++;
        $display("FAIL %s cyc %0d: got ref=%b pin=%b evt=%b flag=%b irq=%b dma=%b dir=%0d act=%0d, expected ref=%b pin=%b evt=%b flag=%b irq=%b dma=%b dir=%0d act=%0d",
                 x.req, cyc, oc_ref, oc_pin, cmp_evt, cmp_flag, ch_irq, ch_dma, dir_q, cmp_active,
                 x.r, x.p, x.e, x.s, x.i, x.d, x.dir, x.act);
      end
    end
  end

  task automatic push_exp(input string req, input int due);
    exp_t x;
    x.due = due; x.req = req;
    x.r = m_ref; x.p = m_en && (m_dir == 2'b00) && m_ref;
    x.e = m_evt; x.s = m_sts; x.i = m_sts && m_ie; x.d = m_dma;
    x.dir = m_dir; x.act = m_act;
    q.push_back(x);
  endtask

  // driver: model one clock edge from current inputs, push expectation, advance
  task automatic tick(input string req);
    logic hit, lt, n_ref;
    hit = (m_dir == 2'b00) && (cnt_val == m_act);
    lt  = cnt_val < m_act;
    n_ref = m_ref;
    if (m_dir == 2'b00) begin
      case (m_mode)
        3'b001: if (hit) n_ref = 1'b1;
        3'b010: if (hit) n_ref = 1'b0;
        3'b011: if (hit) n_ref = ~m_ref;
        3'b100: n_ref = 1'b0;
        3'b101: n_ref = 1'b1;
        3'b110: n_ref = lt;
        3'b111: n_ref = ~lt;
        default: n_ref = m_ref;
      endcase
    end
    m_dma = m_de && (m_sel ? upd_evt : hit);
    m_evt = hit;
    m_sts = hit || (m_sts && !sts_clr);
    m_ref = n_ref;
    if (upd_evt) m_act = m_pre;
    if (pre_we)  m_pre = pre_data;
    if (cfg_we) begin
      if (!m_en) m_dir = cfg_dir;
      m_mode = cfg_mode; m_en = cfg_en; m_sel = cfg_dma_upd;
      m_ie = cfg_irq_en; m_de = cfg_dma_en;
    end
    push_exp(req, cyc + 1);
    @(posedge clk);
    #2;
    cfg_we = 0; pre_we = 0; upd_evt = 0; sts_clr = 0;
  endtask

  task automatic set_cfg(input logic [2:0] mode, input logic [1:0] dir, input logic en,
                         input logic sel, input logic ie, input logic de, input string req);
    cfg_mode = mode; cfg_dir = dir; cfg_en = en; cfg_dma_upd = sel;
    cfg_irq_en = ie; cfg_dma_en = de; cfg_we = 1;
    tick(req);
  endtask

  task automatic sweep(input int lo, input int hi, input string req);
    for (int c = lo; c <= hi; c++) begin
      cnt_val = W'(c);
      tick(req);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog: got run still active, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; cfg_we = 0; cfg_mode = 0; cfg_dir = 0; cfg_en = 0; cfg_dma_upd = 0;
    cfg_irq_en = 0; cfg_dma_en = 0; pre_we = 0; pre_data = 0; upd_evt = 0;
    sts_clr = 0; cnt_val = 16'd100;
    m_mode = 0; m_dir = 0; m_en = 0; m_sel = 0; m_ie = 0; m_de = 0;
    m_ref = 0; m_evt = 0; m_sts = 0; m_dma = 0; m_pre = 0; m_act = 0;
    repeat (3) @(posedge clk);
    #2 rst = 0;
    push_exp("R12 reset state", cyc);

    // R8: shadow write alone leaves active value; update copies it
    pre_data = 16'd10; pre_we = 1; tick("R8 shadow write");
    tick("R8 no update");
    pre_data = 16'd12; pre_we = 1; upd_evt = 1; tick("R8 update takes old shadow");
    upd_evt = 1; tick("R8 update takes new shadow");
    pre_data = 16'd10; pre_we = 1; tick("R8 rewrite");
    upd_evt = 1; tick("R8 reload 10");

    // R5 PWM modes, enabled, R7 pin follows
    set_cfg(3'b110, 2'b00, 1, 0, 0, 0, "R5 pwm A cfg");
    sweep(0, 14, "R5 pwm A sweep");
    sts_clr = 1; tick("R9 clear flag");
    set_cfg(3'b111, 2'b00, 1, 0, 0, 0, "R5 pwm B cfg");
    sweep(5, 14, "R5 pwm B sweep");

    // R2 set and clear
    set_cfg(3'b010, 2'b00, 1, 0, 0, 0, "R2 clear cfg");
    sweep(8, 12, "R2 clear on match");
    set_cfg(3'b001, 2'b00, 1, 0, 0, 0, "R2 set cfg");
    sweep(8, 12, "R2 set on match");
    set_cfg(3'b010, 2'b00, 1, 0, 0, 0, "R2 clear cfg2");
    sweep(9, 11, "R2 clear again");

    // R3 toggle, including a held match
    set_cfg(3'b011, 2'b00, 1, 0, 0, 0, "R3 toggle cfg");
    sweep(8, 12, "R3 toggle sweep");
    cnt_val = 16'd10;
    repeat (3) tick("R3 toggle held match");

    // R1 hold
    set_cfg(3'b000, 2'b00, 1, 0, 0, 0, "R1 hold cfg");
    sweep(0, 14, "R1 hold sweep");

    // R4 forced levels
    set_cfg(3'b100, 2'b00, 1, 0, 0, 0, "R4 force low");
    sweep(9, 11, "R4 force low sweep");
    set_cfg(3'b101, 2'b00, 1, 0, 0, 0, "R4 force high");
    sweep(9, 11, "R4 force high sweep");

    // R7 disabled channel: reference high, pin low
    set_cfg(3'b101, 2'b00, 0, 0, 0, 0, "R7 disable");
    tick("R7 pin gated");

    // R6 direction lock
    set_cfg(3'b011, 2'b00, 1, 0, 0, 0, "R6 enable");
    set_cfg(3'b011, 2'b01, 1, 0, 0, 0, "R6 locked write");
    set_cfg(3'b011, 2'b10, 0, 0, 0, 0, "R6 locked while disabling");
    set_cfg(3'b011, 2'b11, 0, 0, 0, 0, "R6 unlocked write");
    sts_clr = 1; tick("R9 clear before input sweep");
    sweep(8, 12, "R6 input dir no events");
    set_cfg(3'b011, 2'b00, 0, 0, 0, 0, "R6 back to output");

    // R10 / R11 DMA and interrupt
    set_cfg(3'b011, 2'b00, 1, 0, 1, 1, "R10 dma on match cfg");
    sweep(8, 12, "R10 dma on match");
    sts_clr = 1; tick("R11 irq follows cleared flag");
    set_cfg(3'b011, 2'b00, 1, 1, 1, 1, "R10 dma on update cfg");
    sweep(8, 11, "R10 no dma on match");
    upd_evt = 1; tick("R10 dma on update");
    tick("R10 dma pulse ends");
    set_cfg(3'b011, 2'b00, 1, 0, 0, 0, "R11 gates off");
    sweep(9, 11, "R11 no irq no dma");
    upd_evt = 1; tick("R11 update no dma");

    // R9 set wins over clear
    cnt_val = 16'd10; sts_clr = 1; tick("R9 set wins");
    cnt_val = 16'd3;  sts_clr = 1; tick("R9 clear alone");
    tick("R9 idle");

    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule